// File: doc/BRIEF.md
# External Program Fetch Strobe Sequencer

This block times the active-low read strobe that fetches code from external program memory. A machine cycle spans twelve oscillator clocks; the block counts those twelve phases and, in every cycle that fetches externally, drives two strobe pulses of three clocks each. The pulses start at phase 3 and at phase 9. A cycle that also moves data to or from external data memory gives up both of its code strobes, so the data bus is free for the transfer.

At each machine-cycle boundary the block decides whether the next cycle's code comes from outside. It fetches externally when the external-access strap reads low, or when the program address lies at or above the on-chip code limit. It fetches internally when the strap reads high and the address lies below that limit. With the lock input high, the strap level captured during reset is used in place of the live pin, so later changes on the pin have no effect. With the lock input low, the live strap is read again at every boundary.

The sequencer is a five-state machine driven by the phase count:
- `ST_LEAD` (phases 0–2) moves to `ST_PULSE_A` after phase 2.
- `ST_PULSE_A` (phases 3–5) moves to `ST_MID` after phase 5.
- `ST_MID` (phases 6–8) moves to `ST_PULSE_B` after phase 8.
- `ST_PULSE_B` (phases 9–11) returns to `ST_LEAD` after the last phase. If the second pulse ends before the last phase, it moves to `ST_TAIL` instead.
- `ST_TAIL` returns to `ST_LEAD` after the last phase.

The strobe is low only in the two pulse states, and only when the current cycle fetches externally and carries no data access.

Top module: `fetch_strobe_seq`

## Requirements
- R1: `phase` counts 0,1,…,11 and returns to 0, advancing by one on every clock.
- R2: While `rst` is high at a clock edge, the following edge state is `phase` = 0, `pse_n` = 1 and `fetch_ext` = 0. Reset may interrupt a pulse. The first machine cycle after reset carries no strobe.
- R3: In an external code cycle without a data access, `pse_n` is 0 exactly in phases 3, 4, 5, 9, 10 and 11 and is 1 in all other phases.
- R4: If `dmem_cycle` is 1 at the clock edge where `phase` leaves 11, `pse_n` stays 1 for the whole following machine cycle.
- R5: With `code_strap` = 0 (lock off), every address from 0000h to FFFFh gives an external cycle.
- R6: With `code_strap` = 1, addresses below 2000h give an internal cycle with `pse_n` held at 1. Addresses of 2000h and above give an external cycle.
- R7: With `lock_prog` = 1, the `code_strap` level present during reset decides the cycle, and later `code_strap` changes are ignored.
- R8: With `lock_prog` = 0, `code_strap` is sampled again at each edge where `phase` leaves 11.
- R9: `fetch_ext` changes only at the start of a machine cycle (when `phase` becomes 0), and `pse_n` is never 0 while `fetch_ext` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high; also the capture window for the strap |
| code_strap | input | 1 | External-access strap: 0 forces external code, 1 allows on-chip code |
| lock_prog | input | 1 | 1 selects the strap level captured during reset |
| pc_addr | input | 16 | Address of the code fetched in the next machine cycle |
| dmem_cycle | input | 1 | Next machine cycle performs an external data access |
| pse_n | output | 1 | Program memory read strobe, active low |
| fetch_ext | output | 1 | Current machine cycle fetches code externally |
| phase | output | 4 | Oscillator phase within the machine cycle, 0 to 11 |

## Verification
The assertions assume that `code_strap`, `lock_prog`, `pc_addr` and `dmem_cycle` are stable at the edge where `phase` leaves 11, since that edge is the only point where they are read. They also assume that `lock_prog` does not change during reset, because the captured strap is compared against the live pin only under the lock. The stimulus changes these inputs only on a falling clock edge, either while `phase` reads 11 or while reset is held. Every value the block samples is therefore settled a half period before its edge.

// File: rtl/fetch_strobe_pkg.sv
package fetch_strobe_pkg;

    // Position of the sequencer inside one machine cycle.
    typedef enum logic [2:0] {
        ST_LEAD,
        ST_PULSE_A,
        ST_MID,
        ST_PULSE_B,
        ST_TAIL
    } strobe_state_e;

endpackage

// File: rtl/mc_phase_ctr.sv
module mc_phase_ctr #(
    parameter int CYC_LEN = 12,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            wrap
);
    localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)               phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    // High in the final phase: the next edge opens a new machine cycle.
    assign wrap = (phase == LAST);
endmodule

// File: rtl/cycle_plan.sv
module cycle_plan #(
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_LIMIT = 'h2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic              code_strap,
    input  logic              lock_prog,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              dmem_cycle,
    output logic              cyc_ext,
    output logic              cyc_data
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(ONCHIP_LIMIT);

    logic held_strap;
    logic eff_strap;
    logic above_chip;

    // The strap is captured on every clock that reset is held.
    always_ff @(posedge clk) begin
        if (rst) held_strap <= code_strap;
    end

    assign eff_strap  = lock_prog ? held_strap : code_strap;
    assign above_chip = ({1'b0, pc_addr} >= LIMIT);

    // The decision for a whole machine cycle is taken at its opening edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_ext  <= 1'b0;
            cyc_data <= 1'b0;
        end else if (wrap) begin
            cyc_ext  <= !eff_strap || above_chip;
            cyc_data <= dmem_cycle;
        end
    end
endmodule

// File: rtl/strobe_fsm.sv
module strobe_fsm
    import fetch_strobe_pkg::*;
#(
    parameter int CYC_LEN      = 12,
    parameter int FIRST_START  = 3,
    parameter int SECOND_START = 9,
    parameter int PULSE_LEN    = 3,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PH_W-1:0] phase,
    input  logic            cyc_ext,
    input  logic            cyc_data,
    output logic            pse_n
);
    localparam logic [PH_W-1:0] A_PRE  = PH_W'(FIRST_START - 1);
    localparam logic [PH_W-1:0] A_LAST = PH_W'(FIRST_START + PULSE_LEN - 1);
    localparam logic [PH_W-1:0] B_PRE  = PH_W'(SECOND_START - 1);
    localparam logic [PH_W-1:0] B_LAST = PH_W'(SECOND_START + PULSE_LEN - 1);
    localparam logic [PH_W-1:0] C_LAST = PH_W'(CYC_LEN - 1);

    strobe_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LEAD;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LEAD:    if (phase == A_PRE)  state_nxt = ST_PULSE_A;
            ST_PULSE_A: if (phase == A_LAST) state_nxt = ST_MID;
            ST_MID:     if (phase == B_PRE)  state_nxt = ST_PULSE_B;
            ST_PULSE_B: begin
                if (phase == C_LAST)      state_nxt = ST_LEAD;
                else if (phase == B_LAST) state_nxt = ST_TAIL;
            end
            ST_TAIL:    if (phase == C_LAST) state_nxt = ST_LEAD;
            default:    state_nxt = ST_LEAD;
        endcase
    end

    // The strobe is driven from registered state only, so it cannot glitch on inputs.
    always_comb begin
        pse_n = 1'b1;
        if ((state == ST_PULSE_A || state == ST_PULSE_B) && cyc_ext && !cyc_data)
            pse_n = 1'b0;
    end
endmodule

// File: rtl/fetch_strobe_seq.sv
module fetch_strobe_seq #(
    parameter int CYC_LEN      = 12,
    parameter int FIRST_START  = 3,
    parameter int SECOND_START = 9,
    parameter int PULSE_LEN    = 3,
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_LIMIT = 'h2000,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_strap,
    input  logic              lock_prog,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              dmem_cycle,
    output logic              pse_n,
    output logic              fetch_ext,
    output logic [PH_W-1:0]   phase
);
    logic wrap;
    logic cyc_ext;
    logic cyc_data;

    mc_phase_ctr #(.CYC_LEN(CYC_LEN)) i_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .wrap  (wrap)
    );

    cycle_plan #(.ADDR_W(ADDR_W), .ONCHIP_LIMIT(ONCHIP_LIMIT)) i_plan (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .code_strap (code_strap),
        .lock_prog  (lock_prog),
        .pc_addr    (pc_addr),
        .dmem_cycle (dmem_cycle),
        .cyc_ext    (cyc_ext),
        .cyc_data   (cyc_data)
    );

    strobe_fsm #(
        .CYC_LEN      (CYC_LEN),
        .FIRST_START  (FIRST_START),
        .SECOND_START (SECOND_START),
        .PULSE_LEN    (PULSE_LEN)
    ) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .cyc_ext  (cyc_ext),
        .cyc_data (cyc_data),
        .pse_n    (pse_n)
    );

    assign fetch_ext = cyc_ext;
endmodule

// File: rtl/fetch_strobe_chk.sv
module fetch_strobe_chk #(
    parameter int CYC_LEN      = 12,
    parameter int FIRST_START  = 3,
    parameter int SECOND_START = 9,
    parameter int PULSE_LEN    = 3,
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_LIMIT = 'h2000,
    localparam int PH_W = $clog2(CYC_LEN)
) (
    input logic              clk,
    input logic              rst,
    input logic              code_strap,
    input logic              lock_prog,
    input logic [ADDR_W-1:0] pc_addr,
    input logic              dmem_cycle,
    input logic              pse_n,
    input logic              fetch_ext,
    input logic [PH_W-1:0]   phase
);
    localparam logic [PH_W-1:0] C_LAST = PH_W'(CYC_LEN - 1);
    localparam logic [PH_W-1:0] A_FST  = PH_W'(FIRST_START);
    localparam logic [PH_W-1:0] A_LST  = PH_W'(FIRST_START + PULSE_LEN - 1);
    localparam logic [PH_W-1:0] B_FST  = PH_W'(SECOND_START);
    localparam logic [PH_W-1:0] B_LST  = PH_W'(SECOND_START + PULSE_LEN - 1);
    localparam logic [ADDR_W:0] LIM    = (ADDR_W+1)'(ONCHIP_LIMIT);

    logic skip_cyc;
    logic seen_strap;

    always_ff @(posedge clk) begin
        if (rst)                  skip_cyc <= 1'b0;
        else if (phase == C_LAST) skip_cyc <= dmem_cycle;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_strap <= code_strap;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (phase == '0 && pse_n && !fetch_ext)); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        phase == C_LAST |=> phase == '0); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        phase != C_LAST |=> phase == $past(phase) + 1'b1); // R1
    AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !pse_n |-> ((phase >= A_FST && phase <= A_LST) || (phase >= B_FST && phase <= B_LST))); // R3
    AST_DATA_SKIP: assert property (@(posedge clk) disable iff (rst)
        skip_cyc |-> pse_n); // R4
    AST_STRAP_LOW_EXT: assert property (@(posedge clk) disable iff (rst)
        (phase == C_LAST && !code_strap && !lock_prog) |=> fetch_ext); // R5
    AST_HIGH_ADDR_EXT: assert property (@(posedge clk) disable iff (rst)
        (phase == C_LAST && ({1'b0, pc_addr} >= LIM)) |=> fetch_ext); // R6
    AST_LOCK_INTERNAL: assert property (@(posedge clk) disable iff (rst)
        (phase == C_LAST && lock_prog && seen_strap && ({1'b0, pc_addr} < LIM)) |=> !fetch_ext); // R7
    AST_EXT_STEADY: assert property (@(posedge clk) disable iff (rst)
        phase != '0 |-> $stable(fetch_ext)); // R9
    AST_STROBE_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
        !pse_n |-> fetch_ext); // R9
endmodule

bind fetch_strobe_seq fetch_strobe_chk #(
    .CYC_LEN      (CYC_LEN),
    .FIRST_START  (FIRST_START),
    .SECOND_START (SECOND_START),
    .PULSE_LEN    (PULSE_LEN),
    .ADDR_W       (ADDR_W),
    .ONCHIP_LIMIT (ONCHIP_LIMIT)
) i_fetch_strobe_chk (
    .clk        (clk),
    .rst        (rst),
    .code_strap (code_strap),
    .lock_prog  (lock_prog),
    .pc_addr    (pc_addr),
    .dmem_cycle (dmem_cycle),
    .pse_n      (pse_n),
    .fetch_ext  (fetch_ext),
    .phase      (phase)
);

// File: tb/test_fetch_strobe_seq.sv
module test_fetch_strobe_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_strap = 1'b1;
    logic        lock_prog = 1'b0;
    logic [15:0] pc_addr = 16'h0000;
    logic        dmem_cycle = 1'b0;
    logic        pse_n;
    logic        fetch_ext;
    logic [3:0]  phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Vector fields: [18] strap, [17:2] address, [1] data access, [0] expected external.
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 16'h0000, 1'b0, 1'b1},   // R5 lowest address, strap low
        {1'b0, 16'hFFFF, 1'b0, 1'b1},   // R5 highest address, strap low
        {1'b0, 16'h1234, 1'b1, 1'b1},   // R4 data access suppresses both pulses
        {1'b1, 16'h0000, 1'b0, 1'b0},   // R6 internal
        {1'b1, 16'h1FFF, 1'b0, 1'b0},   // R6 last on-chip address
        {1'b1, 16'h2000, 1'b0, 1'b1},   // R6 first off-chip address
        {1'b1, 16'hFFFF, 1'b1, 1'b1},   // R4 off-chip with data access
        {1'b0, 16'h0100, 1'b0, 1'b1}    // R8 strap re-read after going low
    };

    always #2 clk = ~clk;

    fetch_strobe_seq i_fetch_strobe_seq (
        .clk        (clk),
        .rst        (rst),
        .code_strap (code_strap),
        .lock_prog  (lock_prog),
        .pc_addr    (pc_addr),
        .dmem_cycle (dmem_cycle),
        .pse_n      (pse_n),
        .fetch_ext  (fetch_ext),
        .phase      (phase)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Samples one full machine cycle, starting at a falling edge where phase reads 0.
    task automatic obs(input bit strobes, input bit exp_ext, input string req);
        logic [11:0] seen;
        logic [11:0] ph_ok;
        logic [11:0] ext_seen;
        logic [11:0] pat;
        for (int i = 0; i < 12; i++) begin
            seen[i]     = pse_n;
            ph_ok[i]    = (phase == 4'(i));
            ext_seen[i] = fetch_ext;
            @(negedge clk);
        end
        pat = strobes ? 12'h1C7 : 12'hFFF;
        chk(seen == pat, {req, " strobe pattern (R3)"}, 32'(seen), 32'(pat));
        chk(ph_ok == 12'hFFF, {req, " phase sequence R1"}, 32'(ph_ok), 32'hFFF);
        chk(ext_seen == {12{exp_ext}}, {req, " fetch_ext R9"}, 32'(ext_seen), 32'({12{exp_ext}}));
    endtask

    task automatic run_mc(input bit strap, input logic [15:0] addr, input bit dm,
                          input bit exp_ext, input string req);
        while (phase != 4'd11) @(negedge clk);
        code_strap = strap;
        pc_addr    = addr;
        dmem_cycle = dm;
        @(negedge clk);
        obs(exp_ext && !dm, exp_ext, req);
    endtask

    task automatic do_reset(input bit strap, input bit lock);
        @(negedge clk);
        rst        = 1'b1;
        code_strap = strap;
        lock_prog  = lock;
        repeat (2) @(negedge clk);
        chk(phase == 4'd0 && pse_n && !fetch_ext, "R2 reset state",
            {fetch_ext, pse_n, phase}, {1'b0, 1'b1, 4'd0});
        rst = 1'b0;
        obs(1'b0, 1'b0, "R2 first cycle after reset");
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1, 1'b0);

        foreach (VEC[k]) begin
            run_mc(VEC[k][18], VEC[k][17:2], VEC[k][1], VEC[k][0], $sformatf("vector %0d", k));
        end

        // R2: reset in the middle of a pulse returns the strobe high at once.
        while (phase != 4'd4) @(negedge clk);
        chk(!pse_n, "R3 strobe low at phase 4", 32'(pse_n), 32'd0);
        rst = 1'b1;
        @(negedge clk);
        chk(pse_n && phase == 4'd0, "R2 reset cuts pulse", {pse_n, phase}, {1'b1, 4'd0});
        rst = 1'b0;
        obs(1'b0, 1'b0, "R2 cycle after mid-pulse reset");

        // R7: strap held high at reset; later low level must be ignored.
        do_reset(1'b1, 1'b1);
        run_mc(1'b0, 16'h0100, 1'b0, 1'b0, "R7 locked high ignores strap low");
        run_mc(1'b0, 16'h3000, 1'b0, 1'b1, "R7 locked high, off-chip address");

        // R7: strap held low at reset; later high level must be ignored.
        do_reset(1'b0, 1'b1);
        run_mc(1'b1, 16'h0100, 1'b0, 1'b1, "R7 locked low ignores strap high");

        // R8: with the lock removed the live strap decides again.
        lock_prog = 1'b0;
        run_mc(1'b1, 16'h0100, 1'b0, 1'b0, "R8 unlocked strap high");
        run_mc(1'b0, 16'h0100, 1'b0, 1'b1, "R8 unlocked strap low");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule